// File: doc/BRIEF.md
# Machine Cycle Bus Sequencer

This block steps each bus transaction of a small 8-bit processor through a fixed sequence of clock states. The states are T1, T2, zero or more wait states and T3. It drives the bus strobes, the address and data outputs and their enables. It also decides when an external master may take the buses. A single system clock replaces the two external clock phases, and each clock state lasts one clock.

The processor core offers a transaction on a request port. The transaction kind is one of instruction fetch, memory read, memory write, port input or port output, and it comes with an address and write data. The block accepts the request on `req_take`. During T1 it puts a status byte on the data bus. It stretches the cycle with wait states while `ready` is low. Read data comes back on `rd_data` with a one-clock `rd_valid` pulse.

Instruction fetches take their address from an internal fetch counter, which reset clears to zero. A bus-hold request is granted only at fixed points: while the core is halted, or at the end of T2 or a wait state in which `ready` is high. The acknowledge timing differs for reads and writes. While the hold lasts, both bus enables are low.

Top module: `mcyc_bus_seq`

## Requirements
- R1: A synchronous active-high `rst` sets `hold_ack`, `sync`, `dbin`, `wait_st`, `addr_oe`, `data_oe` and `rd_valid` low and `wr_n` high. It clears the fetch counter, so the first instruction fetch after reset uses address 0.
- R2: A request is accepted (`req_take` high, combinationally from `req_valid`) when the sequencer is idle, in T3 with no hold pending, or in the hold state while `hold_req` is low. The next clock is T1, in which `sync` is high for exactly that one clock.
- R3: In T1, `addr_oe` and `data_oe` are high. The data bus carries a status byte: bit 0 marks a read direction (fetch, memory read, port input), bit 1 a write (memory write, port output), bit 2 a port access and bit 3 an instruction fetch. Bits 7..4 are zero.
- R4: Kind codes are 0 fetch, 1 memory read, 2 memory write, 3 port input and 4 port output; codes 5 to 7 behave as memory read. A fetch takes its address from the fetch counter, which then adds 1. A memory access uses `req_addr`. A port access puts the 8-bit device number `req_addr[7:0]` on both address bytes.
- R5: When `ready` is low at the clock ending T2 or a wait state, a wait state follows. `wait_st` is high in wait states only.
- R6: For read kinds, `dbin` is high in T2, in wait states and in T3. `data_in` sampled at the clock ending T3 appears on `rd_data`, with `rd_valid` high for the one following clock.
- R7: For write kinds, `wr_n` is low and `data_oe` is high in T2, in wait states and in T3, with `data_out` equal to the request's write data for that whole time.
- R8: `hold_req` is taken only at the clock ending T2 or a wait state while `ready` is high, or while the sequencer is idle with `halted` high. At any other time it has no effect on `hold_ack`.
- R9: For a read kind with a taken hold, `hold_ack` rises in T3, while the address is still driven.
- R10: For a write kind with a taken hold, `hold_ack` stays low in T3 and rises in the clock after T3.
- R11: In the hold state, `hold_ack` is high and `addr_oe` and `data_oe` are low for as long as `hold_req` stays high. After `hold_req` falls, `hold_ack` falls at the next clock. A request offered in the release clock starts at T1.
- R12: While `halted` is high, requests are not accepted and no T1 starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core offers a transaction |
| req_kind | input | 3 | Transaction kind code |
| req_addr | input | 16 | Memory address or device number in the low byte |
| req_wdata | input | 8 | Write data |
| req_take | output | 1 | Request accepted this clock |
| halted | input | 1 | Core is halted |
| ready | input | 1 | Memory or device ready |
| hold_req | input | 1 | External master asks for the buses |
| data_in | input | 8 | Data read from the bus |
| sync | output | 1 | High in T1 |
| dbin | output | 1 | Data bus in input direction |
| wr_n | output | 1 | Active-low write strobe |
| wait_st | output | 1 | High in a wait state |
| hold_ack | output | 1 | Buses handed to the external master |
| addr_out | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| data_out | output | 8 | Data bus value (status or write data) |
| data_oe | output | 1 | Data bus drive enable |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | Read data valid for one clock |

## Verification
Two functions can fall in the same clock. The first pair is hold acceptance and wait-state insertion. The bench raises `hold_req` from T1 onward and keeps `ready` low for up to two wait states, so the hold is pending while the cycle is stretched. It then checks that `hold_ack` stays low until the clock in which `ready` is high, and rises in T3 for reads and one clock later for writes. The second pair is hold release and a new request. The bench drops `hold_req` and raises `req_valid` in the same clock, and expects `req_take` in that clock and `sync` in the next.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int ADDR_W_DEF = 16;
    localparam int DATA_W_DEF = 8;
    localparam int PORT_W_DEF = 8;
    localparam int KIND_W     = 3;

    // Transaction kind codes seen on req_kind
    localparam logic [KIND_W-1:0] KIND_FETCH  = 3'd0;
    localparam logic [KIND_W-1:0] KIND_MREAD  = 3'd1;
    localparam logic [KIND_W-1:0] KIND_MWRITE = 3'd2;
    localparam logic [KIND_W-1:0] KIND_PIN    = 3'd3;
    localparam logic [KIND_W-1:0] KIND_POUT   = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_HOLD = 3'd5
    } tstate_e;

    typedef struct packed {
        logic is_fetch;
        logic is_port;
        logic is_write;
        logic is_read;
    } cyc_attr_t;

    function automatic cyc_attr_t decode_kind(input logic [KIND_W-1:0] k);
        cyc_attr_t a;
        a = '0;
        unique case (k)
            KIND_FETCH:  begin a.is_fetch = 1'b1; a.is_read = 1'b1; end
            KIND_MWRITE: a.is_write = 1'b1;
            KIND_PIN:    begin a.is_port = 1'b1; a.is_read = 1'b1; end
            KIND_POUT:   begin a.is_port = 1'b1; a.is_write = 1'b1; end
            default:     a.is_read = 1'b1;
        endcase
        return a;
    endfunction

    // Status byte: bit0 read, bit1 write, bit2 port, bit3 fetch
    function automatic logic [7:0] status_byte(input cyc_attr_t a);
        return {4'b0000, a.is_fetch, a.is_port, a.is_write, a.is_read};
    endfunction

    function automatic logic in_data_phase(input tstate_e s);
        return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
    endfunction

endpackage

// File: rtl/mcyc_req_latch.sv
module mcyc_req_latch
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int PORT_W = PORT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output cyc_attr_t         attr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    localparam int REPS = ADDR_W / PORT_W;
    localparam int REM  = ADDR_W - REPS * PORT_W;

    logic [ADDR_W-1:0] fetch_ctr;
    logic [ADDR_W-1:0] port_addr;
    logic [ADDR_W-1:0] next_addr;
    cyc_attr_t         attr_d;

    // Device number repeated into every byte lane of the address bus
    for (genvar g = 0; g < REPS; g++) begin : g_port_lane
        assign port_addr[g*PORT_W +: PORT_W] = req_addr[PORT_W-1:0];
    end
    if (REM > 0) begin : g_port_rem
        assign port_addr[ADDR_W-1 -: REM] = '0;
    end

    assign attr_d = decode_kind(req_kind);

    always_comb begin
        if (attr_d.is_fetch) begin
            next_addr = fetch_ctr;
        end else if (attr_d.is_port) begin
            next_addr = port_addr;
        end else begin
            next_addr = req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_ctr <= '0;
            attr_q    <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
        end else if (load) begin
            attr_q  <= attr_d;
            addr_q  <= next_addr;
            wdata_q <= req_wdata;
            if (attr_d.is_fetch) begin
                fetch_ctr <= fetch_ctr + ADDR_W'(1);
            end
        end
    end

    a_r4_fetch_step: assert property (@(posedge clk) disable iff (rst)
        (load && attr_d.is_fetch) |=> (fetch_ctr == $past(fetch_ctr) + ADDR_W'(1)));

    a_r7_wdata_held: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> $stable(wdata_q));

endmodule

// File: rtl/mcyc_fsm.sv
module mcyc_fsm
    import mcyc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      halted,
    input  logic      ready,
    input  logic      hold_req,
    output logic      accept,
    output tstate_e   state,
    output logic      hold_pend
);

    tstate_e state_d;
    logic    hold_pend_d;
    logic    can_start;

    always_comb begin
        unique case (state)
            ST_IDLE: can_start = !(halted && hold_req);
            ST_T3:   can_start = !hold_pend;
            ST_HOLD: can_start = !hold_req;
            default: can_start = 1'b0;
        endcase
    end

    assign accept = req_valid && !halted && can_start;

    always_comb begin
        state_d     = state;
        hold_pend_d = hold_pend;
        unique case (state)
            ST_IDLE: begin
                if (halted && hold_req) begin
                    state_d = ST_HOLD;
                end else if (accept) begin
                    state_d = ST_T1;
                end
            end
            ST_T1: state_d = ST_T2;
            ST_T2, ST_TW: begin
                if (ready) begin
                    state_d     = ST_T3;
                    hold_pend_d = hold_req;
                end else begin
                    state_d = ST_TW;
                end
            end
            ST_T3: begin
                hold_pend_d = 1'b0;
                if (hold_pend) begin
                    state_d = ST_HOLD;
                end else if (accept) begin
                    state_d = ST_T1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!hold_req) begin
                    state_d = accept ? ST_T1 : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hold_pend <= 1'b0;
        end else begin
            state     <= state_d;
            hold_pend <= hold_pend_d;
        end
    end

    a_r2_t1_single: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T1) |=> (state == ST_T2));

    a_r5_wait_needs_low_ready: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TW) |-> !$past(ready));

    a_r5_t3_needs_ready: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T3) |-> $past(ready));

    a_r12_no_start_halted: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T1) |-> !$past(halted));

endmodule

// File: rtl/mcyc_bus_drive.sv
module mcyc_bus_drive
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  tstate_e           state,
    input  logic              halted,
    input  cyc_attr_t         attr_q,
    input  logic              hold_pend,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] data_in,
    output logic              sync,
    output logic              dbin,
    output logic              wr_n,
    output logic              wait_st,
    output logic              hold_ack,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic              data_ph;
    logic [DATA_W-1:0] stat_ext;

    assign data_ph = in_data_phase(state);

    always_comb begin
        stat_ext      = '0;
        stat_ext[7:0] = status_byte(attr_q);
    end

    assign sync     = (state == ST_T1);
    assign wait_st  = (state == ST_TW);
    assign addr_oe  = sync || data_ph;
    assign addr_out = addr_q;
    assign dbin     = data_ph && attr_q.is_read;
    assign wr_n     = !(data_ph && attr_q.is_write);
    assign data_oe  = sync || (data_ph && attr_q.is_write);
    assign data_out = sync ? stat_ext : wdata_q;
    assign hold_ack = (state == ST_HOLD) ||
                      ((state == ST_T3) && hold_pend && attr_q.is_read);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= (state == ST_T3) && attr_q.is_read;
            if ((state == ST_T3) && attr_q.is_read) begin
                rd_data <= data_in;
            end
        end
    end

    a_r7_write_data_stable: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !$past(wr_n)) |-> $stable(data_out));

    a_r6_dir_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dbin && !wr_n));

    a_r11_bus_released: assert property (@(posedge clk) disable iff (rst)
        (hold_ack && $past(hold_ack)) |-> (!addr_oe && !data_oe));

    a_r9_read_ack_in_t3: assert property (@(posedge clk) disable iff (rst)
        ($rose(hold_ack) && addr_oe) |-> dbin);

    a_r8_ack_rise_point: assert property (@(posedge clk) disable iff (rst)
        ($rose(hold_ack) && !addr_oe) |->
            ($past(state) == ST_T3 || ($past(state) == ST_IDLE && $past(halted))));

    a_r6_rd_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid || $past(state == ST_T3));

endmodule

// File: rtl/mcyc_bus_seq.sv
module mcyc_bus_seq
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int PORT_W = PORT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_take,
    input  logic              halted,
    input  logic              ready,
    input  logic              hold_req,
    input  logic [DATA_W-1:0] data_in,
    output logic              sync,
    output logic              dbin,
    output logic              wr_n,
    output logic              wait_st,
    output logic              hold_ack,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    tstate_e           state;
    logic              hold_pend;
    logic              accept;
    cyc_attr_t         attr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign req_take = accept;

    mcyc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .halted    (halted),
        .ready     (ready),
        .hold_req  (hold_req),
        .accept    (accept),
        .state     (state),
        .hold_pend (hold_pend)
    );

    mcyc_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PORT_W (PORT_W)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .attr_q    (attr_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q)
    );

    mcyc_bus_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_drive (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .halted    (halted),
        .attr_q    (attr_q),
        .hold_pend (hold_pend),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .data_in   (data_in),
        .sync      (sync),
        .dbin      (dbin),
        .wr_n      (wr_n),
        .wait_st   (wait_st),
        .hold_ack  (hold_ack),
        .addr_out  (addr_out),
        .addr_oe   (addr_oe),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    a_r10_write_ack_after_t3: assert property (@(posedge clk) disable iff (rst)
        (hold_ack && !$past(hold_ack) && !$past(wr_n)) |-> (wr_n && !addr_oe));

endmodule

// File: tb/mcyc_bus_seq_tb_top.sv
module mcyc_bus_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_take;
    logic        halted;
    logic        ready;
    logic        hold_req;
    logic [7:0]  data_in;
    logic        sync, dbin, wr_n, wait_st, hold_ack;
    logic [15:0] addr_out;
    logic        addr_oe;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [7:0]  rd_data;
    logic        rd_valid;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] model_ctr = 16'h0000;
    string addr_tag = "R4";

    always #(CLK_PERIOD/2) clk = ~clk;

    mcyc_bus_seq dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_take(req_take),
        .halted(halted), .ready(ready), .hold_req(hold_req), .data_in(data_in),
        .sync(sync), .dbin(dbin), .wr_n(wr_n), .wait_st(wait_st),
        .hold_ack(hold_ack), .addr_out(addr_out), .addr_oe(addr_oe),
        .data_out(data_out), .data_oe(data_oe),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    // One full transaction with nw wait states and an optional hold
    task automatic run_cyc(input int kind, input logic [15:0] a,
                           input logic [7:0] wd, input int nw,
                           input bit hh, input int hlen);
        bit rd, wr, io, fe;
        logic [15:0] exp_addr;
        logic [7:0]  stat;
        logic [7:0]  rdv;
        fe = (kind == 0);
        wr = (kind == 2) || (kind == 4);
        rd = !wr;
        io = (kind == 3) || (kind == 4);
        if (fe) begin
            exp_addr  = model_ctr;
            model_ctr = model_ctr + 16'd1;
        end else if (io) begin
            exp_addr = {a[7:0], a[7:0]};
        end else begin
            exp_addr = a;
        end
        stat = {4'b0000, fe, io, wr, rd};
        rdv  = wd ^ 8'h5A;

        tick;
        req_valid = 1'b1; req_kind = 3'(kind); req_addr = a; req_wdata = wd;
        #1 chk("R2", "req_take", 32'(req_take), 32'd1);
        tick;
        req_valid = 1'b0; hold_req = hh; ready = 1'b0;
        #1;
        chk("R2", "sync in T1", 32'(sync), 32'd1);
        chk("R3", "status byte", 32'(data_out), 32'(stat));
        chk("R3", "data_oe in T1", 32'(data_oe), 32'd1);
        chk(addr_tag, "address", 32'(addr_out), 32'(exp_addr));
        chk("R3", "addr_oe in T1", 32'(addr_oe), 32'd1);
        for (int k = 0; k <= nw; k++) begin
            tick;
            ready = (k == nw);
            #1;
            chk("R5", "wait_st", 32'(wait_st), 32'(k > 0));
            chk("R2", "sync after T1", 32'(sync), 32'd0);
            chk("R6", "dbin T2/TW", 32'(dbin), 32'(rd));
            chk("R7", "wr_n T2/TW", 32'(wr_n), 32'(!wr));
            if (wr) chk("R7", "write data T2/TW", 32'(data_out), 32'(wd));
            chk("R8", "no ack before ready", 32'(hold_ack), 32'd0);
        end
        tick;
        ready = 1'b0; data_in = rdv;
        #1;
        if (rd) chk("R9", "read ack in T3", 32'(hold_ack), 32'(hh));
        else    chk("R10", "write no ack in T3", 32'(hold_ack), 32'd0);
        chk("R6", "dbin T3", 32'(dbin), 32'(rd));
        chk("R7", "wr_n T3", 32'(wr_n), 32'(!wr));
        if (wr) chk("R7", "write data T3", 32'(data_out), 32'(wd));
        chk("R5", "wait_st T3", 32'(wait_st), 32'd0);
        tick;
        #1;
        chk("R6", "rd_valid", 32'(rd_valid), 32'(rd));
        if (rd) chk("R6", "rd_data", 32'(rd_data), 32'(rdv));
        if (hh) begin
            chk("R10", "ack after T3", 32'(hold_ack), 32'd1);
            chk("R11", "addr released", 32'(addr_oe), 32'd0);
            chk("R11", "data released", 32'(data_oe), 32'd0);
            for (int j = 0; j < hlen; j++) begin
                tick;
                #1;
                chk("R11", "ack held", 32'(hold_ack), 32'd1);
                chk("R11", "addr released held", 32'(addr_oe), 32'd0);
                chk("R6", "rd_valid one clock", 32'(rd_valid), 32'd0);
            end
            tick;
            hold_req = 1'b0;
            #1 chk("R11", "ack before release edge", 32'(hold_ack), 32'd1);
            tick;
            #1 chk("R11", "ack dropped", 32'(hold_ack), 32'd0);
        end else begin
            chk("R8", "no ack without hold", 32'(hold_ack), 32'd0);
            chk("R2", "idle after T3", 32'(sync), 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary;
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 3'd0; req_addr = 16'h0;
        req_wdata = 8'h0; halted = 1'b0; ready = 1'b0; hold_req = 1'b0;
        data_in = 8'h0;
        repeat (3) tick;
        #1;
        chk("R1", "hold_ack in reset", 32'(hold_ack), 32'd0);
        chk("R1", "addr_oe in reset", 32'(addr_oe), 32'd0);
        chk("R1", "data_oe in reset", 32'(data_oe), 32'd0);
        chk("R1", "wr_n in reset", 32'(wr_n), 32'd1);
        chk("R1", "dbin/sync/wait in reset", 32'({dbin, sync, wait_st, rd_valid}), 32'd0);
        rst = 1'b0;

        // first fetch after reset must use address 0
        addr_tag = "R1";
        run_cyc(0, 16'hFFFF, 8'h00, 0, 1'b0, 0);
        addr_tag = "R4";

        // sweep kinds x wait counts x hold
        for (int kind = 0; kind < 6; kind++) begin
            for (int nw = 0; nw < 3; nw++) begin
                for (int hh = 0; hh < 2; hh++) begin
                    run_cyc(kind, 16'(16'h1234 * (kind + 1) + nw * 16 + hh),
                            8'(8'h31 * (kind + 1) + nw + hh * 8'h80),
                            nw, hh[0], nw + 1);
                end
            end
        end

        // back-to-back from T3 (R2)
        tick;
        req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'hBEEF;
        #1 chk("R2", "take b2b first", 32'(req_take), 32'd1);
        tick; req_valid = 1'b0; ready = 1'b1;
        tick;
        tick; req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h4321; req_wdata = 8'hC3;
        #1 chk("R2", "take in T3", 32'(req_take), 32'd1);
        tick; req_valid = 1'b0;
        #1;
        chk("R2", "sync right after T3", 32'(sync), 32'd1);
        chk("R3", "write status", 32'(data_out), 32'h02);
        tick; tick; tick;
        #1 chk("R2", "idle after b2b", 32'(sync), 32'd0);

        // hold release coinciding with a request (R11)
        tick; req_valid = 1'b1; req_kind = 3'd4; req_addr = 16'h0077; req_wdata = 8'h99;
        tick; req_valid = 1'b0; hold_req = 1'b1; ready = 1'b1;
        tick; tick; tick;
        #1 chk("R10", "port out ack", 32'(hold_ack), 32'd1);
        tick; hold_req = 1'b0; req_valid = 1'b1; req_kind = 3'd3; req_addr = 16'h0042;
        #1 chk("R11", "take on release", 32'(req_take), 32'd1);
        tick; req_valid = 1'b0;
        #1;
        chk("R11", "T1 after release", 32'(sync), 32'd1);
        chk("R4", "port addr both bytes", 32'(addr_out), 32'h4242);
        chk("R11", "ack low after release", 32'(hold_ack), 32'd0);
        tick; tick; tick;

        // hold in idle without halt is ignored (R8)
        hold_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick;
            #1 chk("R8", "idle hold ignored", 32'(hold_ack), 32'd0);
        end
        hold_req = 1'b0;

        // halted: requests refused (R12), hold granted (R8)
        tick; halted = 1'b1; req_valid = 1'b1; req_kind = 3'd1;
        #1 chk("R12", "no take when halted", 32'(req_take), 32'd0);
        tick;
        #1 chk("R12", "no T1 when halted", 32'(sync), 32'd0);
        req_valid = 1'b0; hold_req = 1'b1;
        tick;
        #1;
        chk("R8", "halted hold ack", 32'(hold_ack), 32'd1);
        chk("R11", "halted hold float", 32'({addr_oe, data_oe}), 32'd0);
        hold_req = 1'b0;
        tick;
        #1 chk("R11", "halted hold released", 32'(hold_ack), 32'd0);
        halted = 1'b0;

        // mid-run reset restarts fetching at 0 (R1)
        tick; rst = 1'b1;
        tick; tick; rst = 1'b0;
        model_ctr = 16'h0000;
        addr_tag = "R1";
        run_cyc(0, 16'h5555, 8'h00, 1, 1'b0, 0);
        addr_tag = "R4";
        run_cyc(0, 16'h5555, 8'h00, 0, 1'b0, 0);

        tick;
        summary;
        $finish;
    end

endmodule